// File: doc/BRIEF.md
# Lockable Thermal Trip Controller

This block is the register front end and trip logic of an on-chip digital thermal monitor. It accepts raw codes from a sensor interface together with a sample strobe. Each code is scaled to degrees Centigrade by a programmable calibration slope. The registered temperature is then compared against a programmable critical limit. When the hardware shutdown enable is set and the temperature is strictly above the limit, the block raises a shutdown request. That request stays high until reset.

Firmware programs the block over a simple single-cycle register bus made of an address, a write strobe, write data and registered read data. One write-once lock bit freezes all three settings that decide whether an overheat is detected and acted on: the limit, the slope and the shutdown enable. Software therefore cannot defeat the protection by changing a setting that the lock leaves open. Only reset clears the lock.

Register map (byte offsets): 0x00 critical limit, 0x04 calibration slope, 0x08 lock, 0x0C shutdown control, 0x10 current temperature.

Top module: `therm_guard_top`

## Requirements
- R1: After reset the limit reads 125, the slope reads 25, and the lock, shutdown control and temperature registers all read 0.
- R2: The limit register at 0x00 keeps write data bits [7:0]; bits [31:8] read as zero whatever was written.
- R3: The slope register at 0x04 stores and returns all 32 bits of write data.
- R4: The lock register at 0x08 holds the lock in bit 0. Writing 1 sets it, writing 0 leaves it unchanged, and only reset clears it. Bits [31:1] read as zero.
- R5: While the lock is set, writes to the limit, the slope and the shutdown enable are discarded and those values stay unchanged.
- R6: The shutdown control register at 0x0C holds the enable in bit 1. Every other bit reads as zero and ignores writes.
- R7: On a clock edge where raw_valid is high, the temperature register at 0x10 (bits [7:0]) loads min(255, (raw_code × slope) >> 4), using the slope held before that edge. Without raw_valid the temperature holds its value.
- R8: shutdown_req rises on the edge after a cycle in which the enable is set and the registered temperature is strictly greater than the limit. A temperature equal to the limit, or any temperature while the enable is clear, does not raise it.
- R9: Once shutdown_req is high it stays high until reset, even after the temperature falls or the enable is cleared.
- R10: Any address other than the five mapped offsets, including misaligned ones, reads as zero, and writes to it change no register.
- R11: Read data for an address presented in one cycle appears on bus_rdata after the next clock edge. A write takes effect on the edge where bus_we is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| raw_valid | input | 1 | Sensor sample strobe |
| raw_code | input | 8 | Raw sensor code |
| shutdown_req | output | 1 | Sticky hardware shutdown request |

## Verification
The hardest case to reach is an attack made after locking. Software rewrites the slope, the limit or the enable to suppress a trip, and the sensor keeps sampling temperatures that must still trip. The stimulus first runs a randomized unlocked phase, then sets the lock by a directed write, and then issues random writes to every address while feeding samples against the frozen settings. A bench model tracks the expected readback and the sticky request in every cycle. Repeated resets show that the lock and the request clear only through reset.

// File: rtl/thermlock_pkg.sv
// Shared widths, register offsets and reset values for the thermal trip
// controller. Assumes byte addressing with 32-bit registers.
package thermlock_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned TEMP_W     = 8;
    localparam int unsigned RAW_W      = 8;
    localparam int unsigned FRAC_SHIFT = 4;
    localparam int unsigned EN_BIT     = 1;

    localparam logic [ADDR_W-1:0] OFF_LIMIT = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SLOPE = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_LOCK  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_TEMP  = 8'h10;

    localparam logic [TEMP_W-1:0] LIMIT_RST = 8'd125;
    localparam logic [DATA_W-1:0] SLOPE_RST = 32'd25;
endpackage

// File: rtl/therm_regs.sv
// Register file with write-once lock. The lock, once set, discards every
// write to limit, slope and shutdown enable until reset.
// Assumes single-cycle bus; read data registered one cycle after address.
module therm_regs
    import thermlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [TEMP_W-1:0] cur_temp,
    output logic [TEMP_W-1:0] limit_q,
    output logic [DATA_W-1:0] slope_q,
    output logic              en_q,
    output logic              lock_q,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              guarded_we;
    logic [DATA_W-1:0] rd_mux;

    // Protected writes pass only while the lock is clear.
    assign guarded_we = bus_we && !lock_q;

    // Lock: set by writing 1 to bit 0, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (bus_we && bus_addr == OFF_LOCK && bus_wdata[0])
            lock_q <= 1'b1;
    end

    // Protected configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= LIMIT_RST;
            slope_q <= SLOPE_RST;
            en_q    <= 1'b0;
        end else if (guarded_we) begin
            if (bus_addr == OFF_LIMIT) limit_q <= bus_wdata[TEMP_W-1:0];
            if (bus_addr == OFF_SLOPE) slope_q <= bus_wdata;
            if (bus_addr == OFF_CTRL)  en_q    <= bus_wdata[EN_BIT];
        end
    end

    // Read selection; reserved bits and unmapped addresses give zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFF_LIMIT: rd_mux[TEMP_W-1:0] = limit_q;
            OFF_SLOPE: rd_mux = slope_q;
            OFF_LOCK:  rd_mux[0] = lock_q;
            OFF_CTRL:  rd_mux[EN_BIT] = en_q;
            OFF_TEMP:  rd_mux[TEMP_W-1:0] = cur_temp;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/therm_convert.sv
// Converts a raw sensor code to degrees: (raw * slope) >> FRAC_SHIFT,
// saturated at the largest temperature code. Registered on each strobe.
module therm_convert
    import thermlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_valid,
    input  logic [RAW_W-1:0]  raw_code,
    input  logic [DATA_W-1:0] slope,
    output logic [TEMP_W-1:0] temp_q
);
    localparam int unsigned PROD_W = RAW_W + DATA_W;
    localparam logic [PROD_W-1:0] TEMP_MAX = PROD_W'((1 << TEMP_W) - 1);

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] scaled;
    logic [TEMP_W-1:0] temp_n;

    // Scale and saturate.
    always_comb begin
        product = PROD_W'(raw_code) * PROD_W'(slope);
        scaled  = product >> FRAC_SHIFT;
        temp_n  = (scaled > TEMP_MAX) ? '1 : scaled[TEMP_W-1:0];
    end

    // Capture temperature on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         temp_q <= '0;
        else if (raw_valid) temp_q <= temp_n;
    end
endmodule

// File: rtl/therm_trip.sv
// Sticky over-temperature trip: sets when enabled and temperature is
// strictly above the limit; only reset clears it.
module therm_trip
    import thermlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] limit,
    input  logic              enable,
    output logic              trip_q
);
    // Latch the trip condition.
    always_ff @(posedge clk) begin
        if (!rst_n)                       trip_q <= 1'b0;
        else if (enable && temp > limit)  trip_q <= 1'b1;
    end
endmodule

// File: rtl/therm_guard_top.sv
// Top of the lockable thermal trip controller: register file, converter
// and trip latch. Assumes sensor codes are synchronous to clk.
module therm_guard_top
    import thermlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              raw_valid,
    input  logic [RAW_W-1:0]  raw_code,
    output logic              shutdown_req
);
    logic [TEMP_W-1:0] limit_w;
    logic [DATA_W-1:0] slope_w;
    logic              en_w;
    logic              lock_w;
    logic [TEMP_W-1:0] temp_w;

    therm_regs regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .cur_temp(temp_w), .limit_q(limit_w),
        .slope_q(slope_w), .en_q(en_w), .lock_q(lock_w), .bus_rdata(bus_rdata)
    );

    therm_convert conv_i (
        .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_code(raw_code),
        .slope(slope_w), .temp_q(temp_w)
    );

    therm_trip trip_i (
        .clk(clk), .rst_n(rst_n), .temp(temp_w), .limit(limit_w),
        .enable(en_w), .trip_q(shutdown_req)
    );
endmodule

// File: rtl/therm_guard_chk.sv
// Property checker for the thermal trip controller, bound to the top.
module therm_guard_chk
    import thermlock_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              raw_valid,
    input logic              lock_w,
    input logic              en_w,
    input logic [TEMP_W-1:0] limit_w,
    input logic [DATA_W-1:0] slope_w,
    input logic [TEMP_W-1:0] temp_w,
    input logic              shutdown_req
);
    // R4
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |=> lock_w);
    // R5
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |=> ($stable(limit_w) && $stable(slope_w) && $stable(en_w)));
    // R7
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |=> $stable(temp_w));
    // R8
    trip_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && temp_w > limit_w) |=> shutdown_req);
    // R8
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> $past(en_w && temp_w > limit_w));
    // R9
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);
endmodule

bind therm_guard_top therm_guard_chk chk_i (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .lock_w(lock_w),
    .en_w(en_w), .limit_w(limit_w), .slope_w(slope_w), .temp_w(temp_w),
    .shutdown_req(shutdown_req)
);

// File: tb/therm_guard_top_tb_top.sv
module therm_guard_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        raw_valid = 1'b0;
    logic [7:0]  raw_code = '0;
    logic        shutdown_req;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_limit;
    logic [31:0] m_slope;
    logic        m_lock, m_en, m_req;
    logic [7:0]  m_temp;

    always #(CLK_PERIOD/2) clk = ~clk;

    therm_guard_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_valid(raw_valid),
        .raw_code(raw_code), .shutdown_req(shutdown_req)
    );

    function automatic logic [7:0] conv(input logic [7:0] raw, input logic [31:0] s);
        logic [39:0] p;
        p = (40'(raw) * 40'(s)) >> 4;
        return (p > 40'd255) ? 8'hFF : p[7:0];
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return {24'h0, m_limit};
            8'h04: return m_slope;
            8'h08: return {31'h0, m_lock};
            8'h0C: return {30'h0, m_en, 1'b0};
            8'h10: return {24'h0, m_temp};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h04: return "R3";
            8'h08: return "R4";
            8'h0C: return "R6";
            8'h10: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus/sensor cycle; inputs driven at negedge, sampled next negedge.
    task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d,
                         input logic v, input logic [7:0] raw,
                         input bit chk_rd, input string tag);
        logic [31:0] exp_rd;
        logic        n_req;
        logic [7:0]  n_temp;
        bus_we = we; bus_addr = a; bus_wdata = d; raw_valid = v; raw_code = raw;
        exp_rd = model_read(a);
        n_req  = m_req | (m_en && (m_temp > m_limit));
        n_temp = v ? conv(raw, m_slope) : m_temp;
        @(negedge clk);
        if (we) begin
            if (a == 8'h08 && d[0]) m_lock = 1'b1;
            if (!m_lock_before(a)) begin
                if (a == 8'h00) m_limit = d[7:0];
                if (a == 8'h04) m_slope = d;
                if (a == 8'h0C) m_en = d[1];
            end
        end
        m_req = n_req;
        m_temp = n_temp;
        bus_we = 1'b0; raw_valid = 1'b0;
        if (chk_rd) check(tag, bus_rdata, exp_rd);
        check("R8", {31'h0, shutdown_req}, {31'h0, m_req});
    endtask

    // Lock state as it stood before the edge (lock write cannot share an address).
    function automatic bit m_lock_before(input logic [7:0] a);
        return (a == 8'h08) ? 1'b0 : m_lock;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, 8'h0, 1'b0, "");
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cycle(1'b0, a, 32'h0, 1'b0, 8'h0, 1'b1, tag);
    endtask

    task automatic sample(input logic [7:0] raw);
        cycle(1'b0, 8'h20, 32'h0, 1'b1, raw, 1'b0, "");
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_we = 1'b0; raw_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_limit = 8'd125; m_slope = 32'd25; m_lock = 1'b0;
        m_en = 1'b0; m_req = 1'b0; m_temp = 8'd0;
    endtask

    task automatic rand_phase(input int n, input bit allow_lock);
        logic [7:0] addrs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h02, 8'hFC};
        for (int i = 0; i < n; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        we;
            a  = addrs[$urandom_range(0, 7)];
            we = $urandom_range(0, 1);
            d  = $urandom;
            if (a == 8'h04) d = $urandom_range(0, 64);
            if (a == 8'h08 && !allow_lock) d[0] = 1'b0;
            cycle(we, a, d, $urandom_range(0, 1), 8'($urandom_range(0, 255)), !we, tag_of(a));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1233));
        @(negedge clk);
        do_reset();
        // R1 reset values
        rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1");
        rd(8'h0C, "R1"); rd(8'h10, "R1");
        // R10 unmapped writes leave mapped registers alone
        wr(8'h14, 32'hFFFFFFFF); wr(8'h01, 32'hFFFFFFFF); wr(8'hFC, 32'h1);
        rd(8'h14, "R10"); rd(8'h01, "R10"); rd(8'h00, "R10"); rd(8'h08, "R10");
        // R2, R3, R6 field behaviour
        wr(8'h00, 32'hFFFFFF40); rd(8'h00, "R2");
        wr(8'h04, 32'hDEADBEEF); rd(8'h04, "R3");
        wr(8'h0C, 32'hFFFFFFFF); rd(8'h0C, "R6");
        wr(8'h0C, 32'hFFFFFFFD); rd(8'h0C, "R6");
        // R11: read result lands exactly one edge later
        wr(8'h00, 32'h7D);
        cycle(1'b0, 8'h00, 32'h0, 1'b0, 8'h0, 1'b1, "R11");
        cycle(1'b0, 8'h0C, 32'h0, 1'b0, 8'h0, 1'b1, "R11");
        // R7/R8 equal-to-limit does not trip, one above does
        wr(8'h04, 32'd25); wr(8'h0C, 32'h2);
        sample(8'd80); rd(8'h10, "R7");
        rd(8'h10, "R8");
        check("R8", {31'h0, shutdown_req}, 32'h0);
        sample(8'd81); rd(8'h10, "R7");
        check("R8", {31'h0, shutdown_req}, 32'h1);
        // R9 sticky after cooling and disable
        sample(8'd0); wr(8'h0C, 32'h0); rd(8'h10, "R9");
        check("R9", {31'h0, shutdown_req}, 32'h1);
        // R7 saturation and hold; R8 no trip while disabled
        do_reset();
        wr(8'h04, 32'hFFFFFFFF); sample(8'd255); rd(8'h10, "R7");
        cycle(1'b0, 8'h10, 32'h0, 1'b0, 8'd3, 1'b1, "R7");
        rd(8'h10, "R7");
        check("R8", {31'h0, shutdown_req}, 32'h0);
        // random unlocked traffic with periodic resets
        for (int k = 0; k < 4; k++) begin
            do_reset();
            rand_phase(150, 1'b0);
        end
        // R4 write-once lock
        do_reset();
        wr(8'h08, 32'hFFFFFFFE); rd(8'h08, "R4");
        wr(8'h08, 32'h1); rd(8'h08, "R4");
        wr(8'h08, 32'h0); rd(8'h08, "R4");
        // R5 locked writes discarded
        wr(8'h00, 32'h10); rd(8'h00, "R5");
        wr(8'h04, 32'h3);  rd(8'h04, "R5");
        wr(8'h0C, 32'h2);  rd(8'h0C, "R5");
        rand_phase(300, 1'b1);
        rd(8'h08, "R4");
        // lock armed over enabled trip: attempts to disarm must fail
        do_reset();
        wr(8'h0C, 32'h2); wr(8'h00, 32'd100); wr(8'h08, 32'h1);
        wr(8'h0C, 32'h0); wr(8'h04, 32'h0); wr(8'h00, 32'hFF);
        rd(8'h0C, "R5");
        sample(8'd70);
        rd(8'h10, "R5");
        check("R5", {31'h0, shutdown_req}, 32'h1);
        rand_phase(200, 1'b1);
        // R4 only reset clears lock
        do_reset();
        rd(8'h08, "R4");
        wr(8'h00, 32'h33); rd(8'h00, "R4");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule